// File: doc/BRIEF.md
# Floating-Point Result Sign Unit

This block keeps the sign of a floating-point result while a multi-cycle arithmetic sequencer works on the mantissa and exponent. In the cycle an operation is accepted, it loads a starting sign taken from operand B, inverted for an effective subtraction. In the same cycle it captures the subtract and negate flags of the operation. After that, the sequencer changes the running sign through a small 3-bit control code, one action per cycle.

When the result is known, the sequencer pulses a finalize strobe. It also supplies the rounding mode and two flags: one for an exact zero result and one for a NaN result. The block then forms the packed sign. For an exact zero from a subtraction, it forces the rounding-mode zero sign. For the negated multiply-add family, it inverts the sign after that. A NaN keeps its sign unchanged. The packed sign is registered, and the one registered value feeds both the result-class flag logic and the result packer in the following cycle.

Top module: `fp_sign_unit`

## Requirements
- R1: After synchronous reset, `run_sign`, `fin_sign` and `fin_vld` are all 0.
- R2: A cycle with `accept`=1 loads `run_sign` with `acc_b_sign ^ acc_eff_sub` at the next edge, whatever `sign_op` is. The same edge latches `acc_eff_sub` and `acc_negate`.
- R3: When `accept`=0, the codes `sign_op` 000, 110 and 111 leave `run_sign` unchanged. Code 001 inverts it.
- R4: When `accept`=0, code 010 sets `run_sign` to its old value XOR the latched subtract flag.
- R5: When `accept`=0, codes 011, 100 and 101 copy `opa_sign`, `opb_sign` and `opc_sign`, respectively, into `run_sign`.
- R6: On finalize with `res_zero`=1, `res_nan`=0 and the latched subtract flag set, the packed sign before negation is 1 when `rnd_mode`=11 (toward minus infinity). It is 0 for 00 (nearest), 01 (toward zero) and 10 (toward plus infinity).
- R7: On finalize for a non-NaN result that is not a subtraction zero, the packed sign before negation is `run_sign`.
- R8: When the latched negate flag is set and the result is not NaN, the packed sign is inverted after the R6/R7 rule.
- R9: On finalize with `res_nan`=1, the packed sign equals `run_sign`, regardless of `res_zero`, the latched negate flag or the rounding mode.
- R10: The packed sign appears on `fin_sign` one cycle after `fin_en`=1, and `fin_vld` is 1 in exactly that cycle.
- R11: `fin_sign` keeps its value in every cycle that follows a cycle without `fin_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept | input | 1 | Operation accepted this cycle |
| acc_b_sign | input | 1 | Sign of operand B at accept |
| acc_eff_sub | input | 1 | Operation is an effective subtraction |
| acc_negate | input | 1 | Operation negates its final result |
| sign_op | input | 3 | Running-sign action code |
| opa_sign | input | 1 | Current sign of operand A |
| opb_sign | input | 1 | Current sign of operand B |
| opc_sign | input | 1 | Current sign of operand C |
| fin_en | input | 1 | Compute and register the packed sign |
| rnd_mode | input | 2 | Rounding mode |
| res_zero | input | 1 | Result is an exact zero |
| res_nan | input | 1 | Result is a NaN |
| run_sign | output | 1 | Running result sign |
| fin_sign | output | 1 | Registered packed sign |
| fin_vld | output | 1 | `fin_sign` was updated this cycle |

## Verification
The bench targets several corner cases, and each one catches a specific kind of fault:
- **Accept with a non-hold code.** A design that lets the code win over the load shows a wrong starting sign.
- **Spare codes 110 and 111.** A design that decodes them as actions flips or overwrites the running sign.
- **Subtraction zero in all four rounding modes.** A mistake here shows up as a negative zero outside toward-minus-infinity, or as a positive zero in toward-minus-infinity.
- **Zero from a non-subtraction.** A design that ignores the subtract flag loses the running sign here.
- **Negate combined with the zero rule.** A design that negates before forcing the zero sign gives the opposite sign.
- **NaN with the zero and negate flags both raised.** A design that lets zero or negate override NaN alters the NaN sign.
- **Quiet cycles after finalize.** A design that reloads `fin_sign` without a strobe fails the hold checks.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int OP_W = 3;
  localparam int RM_W = 2;

  typedef enum logic [OP_W-1:0] {
    SOP_HOLD  = 3'b000,
    SOP_INV   = 3'b001,
    SOP_XSUB  = 3'b010,
    SOP_CPYA  = 3'b011,
    SOP_CPYB  = 3'b100,
    SOP_CPYC  = 3'b101,
    SOP_SPR6  = 3'b110,
    SOP_SPR7  = 3'b111
  } sop_e;

  localparam logic [RM_W-1:0] RM_DOWN = 2'b11;
endpackage

// File: rtl/fsu_track.sv
module fsu_track
  import fsu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            acc_b_sign,
  input  logic            acc_eff_sub,
  input  logic            acc_negate,
  input  logic [OP_W-1:0] sign_op,
  input  logic            opa_sign,
  input  logic            opb_sign,
  input  logic            opc_sign,
  output logic            run_sign,
  output logic            sub_l,
  output logic            neg_l
);
  logic nxt_sign;

  always_comb begin
    nxt_sign = run_sign;
    case (sign_op)
      SOP_INV:  nxt_sign = ~run_sign;
      SOP_XSUB: nxt_sign = run_sign ^ sub_l;
      SOP_CPYA: nxt_sign = opa_sign;
      SOP_CPYB: nxt_sign = opb_sign;
      SOP_CPYC: nxt_sign = opc_sign;
      default:  nxt_sign = run_sign;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_sign <= 1'b0;
      sub_l    <= 1'b0;
      neg_l    <= 1'b0;
    end else if (accept) begin
      run_sign <= acc_b_sign ^ acc_eff_sub;
      sub_l    <= acc_eff_sub;
      neg_l    <= acc_negate;
    end else begin
      run_sign <= nxt_sign;
    end
  end

  p_accept_init_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> run_sign == ($past(acc_b_sign) ^ $past(acc_eff_sub)));
  p_hold_codes_r3: assert property (@(posedge clk) disable iff (rst)
    (!accept && (sign_op == SOP_HOLD || sign_op == SOP_SPR6 || sign_op == SOP_SPR7))
      |=> $stable(run_sign));
  p_invert_r3: assert property (@(posedge clk) disable iff (rst)
    (!accept && sign_op == SOP_INV) |=> run_sign != $past(run_sign));
  p_copy_a_r5: assert property (@(posedge clk) disable iff (rst)
    (!accept && sign_op == SOP_CPYA) |=> run_sign == $past(opa_sign));
endmodule

// File: rtl/fsu_final.sv
module fsu_final
  import fsu_pkg::*;
(
  input  logic            run_sign,
  input  logic            sub_l,
  input  logic            neg_l,
  input  logic [RM_W-1:0] rnd_mode,
  input  logic            res_zero,
  input  logic            res_nan,
  output logic            pack_sign
);
  logic zsign;

  always_comb begin
    zsign = run_sign;
    if (res_zero && sub_l)
      zsign = (rnd_mode == RM_DOWN);
    if (res_nan)
      pack_sign = run_sign;
    else
      pack_sign = zsign ^ neg_l;
  end

  always_comb begin
    if (res_nan) a_nan_keep_r9: assert (pack_sign == run_sign);
  end
endmodule

// File: rtl/fp_sign_unit.sv
module fp_sign_unit
  import fsu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            acc_b_sign,
  input  logic            acc_eff_sub,
  input  logic            acc_negate,
  input  logic [OP_W-1:0] sign_op,
  input  logic            opa_sign,
  input  logic            opb_sign,
  input  logic            opc_sign,
  input  logic            fin_en,
  input  logic [RM_W-1:0] rnd_mode,
  input  logic            res_zero,
  input  logic            res_nan,
  output logic            run_sign,
  output logic            fin_sign,
  output logic            fin_vld
);
  logic sub_l, neg_l, pack_sign;

  fsu_track i_track (
    .clk(clk), .rst(rst), .accept(accept), .acc_b_sign(acc_b_sign),
    .acc_eff_sub(acc_eff_sub), .acc_negate(acc_negate), .sign_op(sign_op),
    .opa_sign(opa_sign), .opb_sign(opb_sign), .opc_sign(opc_sign),
    .run_sign(run_sign), .sub_l(sub_l), .neg_l(neg_l)
  );

  fsu_final i_final (
    .run_sign(run_sign), .sub_l(sub_l), .neg_l(neg_l), .rnd_mode(rnd_mode),
    .res_zero(res_zero), .res_nan(res_nan), .pack_sign(pack_sign)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_sign <= 1'b0;
      fin_vld  <= 1'b0;
    end else begin
      fin_vld <= fin_en;
      if (fin_en) fin_sign <= pack_sign;
    end
  end

  p_nan_sign_r9: assert property (@(posedge clk) disable iff (rst)
    (fin_en && res_nan) |=> fin_sign == $past(run_sign));
  p_vld_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    fin_en |=> fin_vld);
  p_vld_low_r10: assert property (@(posedge clk) disable iff (rst)
    !fin_en |=> !fin_vld);
  p_fin_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !fin_en |=> $stable(fin_sign));
endmodule

// File: tb/test_fp_sign_unit.sv
module test_fp_sign_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accept = 0, acc_b_sign = 0, acc_eff_sub = 0, acc_negate = 0;
  logic [2:0] sign_op = 3'b000;
  logic opa_sign = 0, opb_sign = 0, opc_sign = 0, fin_en = 0;
  logic [1:0] rnd_mode = 2'b00;
  logic res_zero = 0, res_nan = 0;
  logic run_sign, fin_sign, fin_vld;

  always #10 clk = ~clk;

  fp_sign_unit i_fp_sign_unit (
    .clk(clk), .rst(rst), .accept(accept), .acc_b_sign(acc_b_sign),
    .acc_eff_sub(acc_eff_sub), .acc_negate(acc_negate), .sign_op(sign_op),
    .opa_sign(opa_sign), .opb_sign(opb_sign), .opc_sign(opc_sign),
    .fin_en(fin_en), .rnd_mode(rnd_mode), .res_zero(res_zero),
    .res_nan(res_nan), .run_sign(run_sign), .fin_sign(fin_sign), .fin_vld(fin_vld)
  );

  typedef struct {
    logic  run;
    logic  fs;
    logic  fv;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errs = 0;
  bit done = 0;
  logic m_run = 0, m_sub = 0, m_neg = 0, m_fs = 0;

  task automatic cmp(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: {run,fin,vld} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, {run_sign, fin_sign, fin_vld}, {e.run, e.fs, e.fv});
    end
  end

  task automatic step(input logic acc, input logic bs0, input logic esub, input logic neg,
                      input logic [2:0] op, input logic a, input logic b, input logic c,
                      input logic fin, input logic [1:0] rm, input logic z, input logic n,
                      input string tag);
    exp_t e;
    logic f, nr;
    @(negedge clk);
    accept = acc; acc_b_sign = bs0; acc_eff_sub = esub; acc_negate = neg;
    sign_op = op; opa_sign = a; opb_sign = b; opc_sign = c;
    fin_en = fin; rnd_mode = rm; res_zero = z; res_nan = n;
    f = m_run;
    if (!n) begin
      if (z && m_sub) f = (rm == 2'b11);
      if (m_neg) f = ~f;
    end
    if (fin) m_fs = f;
    nr = m_run;
    if (acc) begin
      nr = bs0 ^ esub; m_sub = esub; m_neg = neg;
    end else begin
      case (op)
        3'b001: nr = ~m_run;
        3'b010: nr = m_run ^ m_sub;
        3'b011: nr = a;
        3'b100: nr = b;
        3'b101: nr = c;
        default: nr = m_run;
      endcase
    end
    m_run = nr;
    e.run = m_run; e.fs = m_fs; e.fv = fin; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input logic [2:0] op, input string tag);
    step(0, 0, 0, 0, op, 0, 0, 0, 0, 2'b00, 0, 0, tag);
  endtask

  task automatic fin(input logic [1:0] rm, input logic z, input logic n, input string tag);
    step(0, 0, 0, 0, 3'b000, 0, 0, 0, 1, rm, z, n, tag);
  endtask

  task automatic acc(input logic b, input logic sub, input logic neg,
                     input logic [2:0] op, input string tag);
    step(1, b, sub, neg, op, 1, 1, 1, 0, 2'b00, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    cmp("R1 reset", {run_sign, fin_sign, fin_vld}, 3'b000);
    @(negedge clk);
    rst = 0;
    acc(1, 0, 0, 3'b000, "R2 b=1 add");
    acc(1, 1, 0, 3'b000, "R2 b=1 sub");
    acc(0, 1, 0, 3'b001, "R2 accept overrides invert");
    idle(3'b000, "R3 hold 000");
    idle(3'b110, "R3 spare 110");
    idle(3'b111, "R3 spare 111");
    idle(3'b001, "R3 invert");
    idle(3'b001, "R3 invert back");
    acc(0, 1, 0, 3'b000, "R2 load sub");
    idle(3'b010, "R4 xor sub=1");
    idle(3'b010, "R4 xor sub=1 again");
    acc(1, 0, 0, 3'b000, "R2 load add");
    idle(3'b010, "R4 xor sub=0");
    step(0, 0, 0, 0, 3'b011, 0, 1, 1, 0, 2'b00, 0, 0, "R5 copy A");
    step(0, 0, 0, 0, 3'b100, 0, 1, 0, 0, 2'b00, 0, 0, "R5 copy B");
    step(0, 0, 0, 0, 3'b101, 1, 1, 0, 0, 2'b00, 0, 0, "R5 copy C");
    step(0, 0, 0, 0, 3'b011, 1, 0, 0, 0, 2'b00, 0, 0, "R5 copy A set");
    fin(2'b00, 0, 0, "R7 plain finalize");
    idle(3'b000, "R11 hold after fin");
    acc(0, 1, 0, 3'b000, "R2 sub for zero");
    idle(3'b001, "R3 make run=0");
    idle(3'b001, "R3 make run=1");
    fin(2'b00, 1, 0, "R6 zero rm nearest");
    fin(2'b01, 1, 0, "R6 zero rm toward zero");
    fin(2'b10, 1, 0, "R6 zero rm plus inf");
    idle(3'b001, "R3 make run=0");
    fin(2'b11, 1, 0, "R6 zero rm minus inf");
    idle(3'b000, "R11 hold quiet 1");
    idle(3'b001, "R11 hold quiet 2");
    acc(1, 0, 0, 3'b000, "R2 add for zero");
    fin(2'b00, 1, 0, "R7 zero without subtract");
    acc(1, 1, 1, 3'b000, "R2 negated sub");
    fin(2'b11, 1, 0, "R8 negate after zero rule rm minus");
    fin(2'b01, 1, 0, "R8 negate after zero rule rm zero");
    fin(2'b01, 0, 0, "R8 negate nonzero");
    idle(3'b001, "R3 flip for nan");
    fin(2'b11, 1, 1, "R9 nan keeps sign");
    idle(3'b001, "R3 flip");
    fin(2'b00, 0, 1, "R9 nan keeps sign 2");
    idle(3'b000, "R10 vld drops");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule